// File: doc/BRIEF.md
# Memory Access Check and Remap

This unit sits in the address path of every load and store. Each presented address is first relocated: when the process-identifier field of the process register is nonzero and the top seven address bits are all zero, that field is ORed into the top of the address, which moves low addresses into the window of the running process. Addresses that already carry upper bits, and every address while the process field is zero, pass through unchanged.

The remapped address then goes through two checks. The first is a word-alignment check that can be switched off. The second is a pair of data-breakpoint comparators. Each comparator has a 2-bit qualifier that selects stores, loads, both, or nothing. In the default mode the two comparators work independently at word granularity. In mask mode the second breakpoint register becomes an inverse mask for the first comparator, and the second comparator is switched off. A debug-gating input suppresses breakpoint evaluation. The unit raises no exception and records no status. It only emits one-cycle pulses, registered one cycle after the request strobe, together with the remapped address.

The output stage is a two-state machine. `MS_IDLE` means no result is being presented. `MS_REPORT` means the outputs carry the result of the request accepted on the previous edge. The transition `TAKE` (any state to `MS_REPORT`) fires on every edge where `req_valid` is high. The transition `DRAIN` (any state to `MS_IDLE`) fires on every edge where it is low.

Top module: `mac_gate`

## Requirements
- R1: After reset, `rsp_valid`, `rsp_addr`, `align_abort` and `bp_hit` are all zero.
- R2: An edge with `req_valid` high makes `rsp_valid` high for the next cycle, and `rsp_addr` then holds the remapped address. An edge with `req_valid` low makes `rsp_valid` low for the next cycle.
- R3: When `pid_reg[31:25]` is nonzero and `req_addr[31:25]` is zero, `rsp_addr` is `req_addr | (pid_reg & 0xFE000000)`.
- R4: When `pid_reg[31:25]` is zero, or `req_addr[31:25]` is nonzero, `rsp_addr` equals `req_addr`.
- R5: `align_abort` pulses with the response exactly when `align_en` was high and `req_addr[1:0]` was nonzero.
- R6: A comparator's 2-bit qualifier selects its access types: 0 matches nothing, 1 matches stores only (`req_store`=1), 2 matches loads and stores, and 3 matches loads only.
- R7: In normal mode (`bp_ctrl[8]`=0), comparator 0 uses `bp_ctrl[1:0]` and `bp_addr0`, and comparator 1 uses `bp_ctrl[3:2]` and `bp_addr1`. Each comparator matches when bits 31:2 of the remapped address equal bits 31:2 of its register. A match on either comparator gives one `bp_hit` pulse.
- R8: In mask mode (`bp_ctrl[8]`=1), only comparator 0 is active, using qualifier `bp_ctrl[1:0]`. It matches when `(a & ~bp_addr1) == (bp_addr0 & ~bp_addr1)`, where `a` is the remapped address. `bp_ctrl[3:2]` has no effect in this mode.
- R9: Breakpoints compare against the remapped address, not the raw request address.
- R10: When `dbg_hold` is high with a request, `bp_hit` stays low for that response.
- R11: `align_abort` and `bp_hit` are never high unless `rsp_valid` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe |
| req_store | input | 1 | 1 = store, 0 = load |
| req_addr | input | 32 | Request address |
| pid_reg | input | 32 | Process register; bits 31:25 are the process field |
| align_en | input | 1 | Enables the alignment check |
| bp_addr0 | input | 32 | Breakpoint register 0 |
| bp_addr1 | input | 32 | Breakpoint register 1, or the inverse mask in mask mode |
| bp_ctrl | input | 32 | Breakpoint control: [1:0] qualifier 0, [3:2] qualifier 1, [8] mask mode |
| dbg_hold | input | 1 | Suppresses breakpoint evaluation |
| rsp_valid | output | 1 | Response valid, one cycle after the request |
| rsp_addr | output | 32 | Remapped address |
| align_abort | output | 1 | Alignment abort pulse |
| bp_hit | output | 1 | Data breakpoint hit pulse |

## Verification
Every piece of state in this block is visible at the ports on the cycle right after the request that set it. A corrupted remap selection shows up as a wrong upper field in `rsp_addr` on the next cycle. A wrongly sliced qualifier, a swapped mask polarity or a stuck mask-mode select shows up as a missing or spurious `bp_hit` on that same response. A state machine that lags or leads appears as `rsp_valid` out of step with `req_valid`. The bench therefore compares all four outputs on every cycle against a model of the requirements. It steers random traffic toward exact, near-miss and masked breakpoint matches.

// File: rtl/mac_pkg.sv
package mac_pkg;

    // Access qualifier carried by each breakpoint comparator
    typedef enum logic [1:0] {
        BPQ_OFF   = 2'd0,
        BPQ_STORE = 2'd1,
        BPQ_ANY   = 2'd2,
        BPQ_LOAD  = 2'd3
    } bp_qual_e;

    // Output stage states
    typedef enum logic {
        MS_IDLE   = 1'b0,
        MS_REPORT = 1'b1
    } mac_state_e;

    // Breakpoint control field positions (decoded by the comparators)
    localparam int CTRL_W        = 32;
    localparam int QUAL_W        = 2;
    localparam int QUAL0_LSB     = 0;
    localparam int QUAL1_LSB     = 2;
    localparam int MASK_MODE_BIT = 8;

endpackage

// File: rtl/mac_remap.sv
module mac_remap #(
    parameter int ADDR_W = 32,
    parameter int PID_W  = 7
) (
    input  logic [ADDR_W-1:0] in_addr,
    input  logic [PID_W-1:0]  pid_field,
    output logic [ADDR_W-1:0] out_addr
);
    localparam int LOW_W = ADDR_W - PID_W;

    logic top_clear;
    logic pid_live;

    always_comb begin
        top_clear = (in_addr[ADDR_W-1:LOW_W] == '0);
        pid_live  = (pid_field != '0);
        if (top_clear && pid_live) begin
            out_addr = {pid_field, in_addr[LOW_W-1:0]};
        end else begin
            out_addr = in_addr;
        end
    end
endmodule

// File: rtl/mac_bp_cmp.sv
module mac_bp_cmp
    import mac_pkg::*;
#(
    parameter int ADDR_W      = 32,
    parameter int IGNORE_LSBS = 2
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [ADDR_W-1:0] bp_reg,
    input  logic [ADDR_W-1:0] dc_mask,
    input  logic              mask_sel,
    input  bp_qual_e          qual,
    input  logic              is_store,
    output logic              hit
);
    localparam logic [ADDR_W-1:0] WORD_DC =
        {{(ADDR_W-IGNORE_LSBS){1'b0}}, {IGNORE_LSBS{1'b1}}};

    logic [ADDR_W-1:0] dont_care;
    logic              qual_ok;
    logic              addr_eq;

    always_comb begin
        unique case (qual)
            BPQ_OFF:   qual_ok = 1'b0;
            BPQ_STORE: qual_ok = is_store;
            BPQ_ANY:   qual_ok = 1'b1;
            BPQ_LOAD:  qual_ok = !is_store;
            default:   qual_ok = 1'b0;
        endcase
        dont_care = mask_sel ? dc_mask : WORD_DC;
        addr_eq   = (((addr ^ bp_reg) & ~dont_care) == '0);
        hit       = qual_ok && addr_eq;
    end
endmodule

// File: rtl/mac_gate.sv
module mac_gate
    import mac_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int PID_W  = 7,
    parameter int NUM_BP = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_store,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [ADDR_W-1:0] pid_reg,
    input  logic              align_en,
    input  logic [ADDR_W-1:0] bp_addr0,
    input  logic [ADDR_W-1:0] bp_addr1,
    input  logic [CTRL_W-1:0] bp_ctrl,
    input  logic              dbg_hold,
    output logic              rsp_valid,
    output logic [ADDR_W-1:0] rsp_addr,
    output logic              align_abort,
    output logic              bp_hit
);
    localparam int LOW_W = ADDR_W - PID_W;

    // Unused fields of the wide inputs
    logic unused_bits;
    assign unused_bits = ^{bp_ctrl[CTRL_W-1:MASK_MODE_BIT+1],
                           bp_ctrl[MASK_MODE_BIT-1:QUAL1_LSB+QUAL_W],
                           pid_reg[LOW_W-1:0]};

    // Remap
    logic [ADDR_W-1:0] mapped_addr;

    mac_remap #(.ADDR_W(ADDR_W), .PID_W(PID_W)) u_remap (
        .in_addr  (req_addr),
        .pid_field(pid_reg[ADDR_W-1:LOW_W]),
        .out_addr (mapped_addr)
    );

    // Breakpoint comparators
    logic              mask_mode;
    logic [ADDR_W-1:0] bp_regs  [NUM_BP];
    bp_qual_e          bp_quals [NUM_BP];
    logic [NUM_BP-1:0] cmp_hit;

    assign mask_mode   = bp_ctrl[MASK_MODE_BIT];
    assign bp_regs[0]  = bp_addr0;
    assign bp_regs[1]  = bp_addr1;
    assign bp_quals[0] = bp_qual_e'(bp_ctrl[QUAL0_LSB +: QUAL_W]);
    assign bp_quals[1] = bp_qual_e'(bp_ctrl[QUAL1_LSB +: QUAL_W]);

    for (genvar g = 0; g < NUM_BP; g++) begin : g_cmp
        mac_bp_cmp #(.ADDR_W(ADDR_W), .IGNORE_LSBS(2)) u_cmp (
            .addr    (mapped_addr),
            .bp_reg  (bp_regs[g]),
            .dc_mask (bp_addr1),
            .mask_sel(mask_mode && (g == 0)),
            .qual    (bp_quals[g]),
            .is_store(req_store),
            .hit     (cmp_hit[g])
        );
    end

    logic hit_now;
    logic misalign_now;

    always_comb begin
        if (dbg_hold) begin
            hit_now = 1'b0;
        end else if (mask_mode) begin
            hit_now = cmp_hit[0];
        end else begin
            hit_now = |cmp_hit;
        end
        misalign_now = align_en && (req_addr[1:0] != 2'b00);
    end

    // Output stage state machine
    mac_state_e state_q, state_d;

    always_comb begin
        unique case (state_q)
            MS_IDLE:   state_d = req_valid ? MS_REPORT : MS_IDLE;
            MS_REPORT: state_d = req_valid ? MS_REPORT : MS_IDLE;
            default:   state_d = MS_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= MS_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsp_addr    <= '0;
            align_abort <= 1'b0;
            bp_hit      <= 1'b0;
        end else if (req_valid) begin
            rsp_addr    <= mapped_addr;
            align_abort <= misalign_now;
            bp_hit      <= hit_now;
        end else begin
            align_abort <= 1'b0;
            bp_hit      <= 1'b0;
        end
    end

    assign rsp_valid = (state_q == MS_REPORT);

    // R2
    rsp_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);

    // R2
    rsp_drops_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);

    // R4
    no_remap_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_addr[ADDR_W-1:LOW_W] != '0) |=> rsp_addr == $past(req_addr));

    // R10
    hold_blocks_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && dbg_hold) |=> !bp_hit);

    // R11
    pulse_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bp_hit || align_abort) |-> rsp_valid);

    // R5
    no_abort_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !align_en) |=> !align_abort);
endmodule

// File: tb/mac_gate_tb.sv
module mac_gate_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_store = 1'b0, align_en = 1'b0, dbg_hold = 1'b0;
    logic [31:0] req_addr = '0, pid_reg = '0, bp_addr0 = '0, bp_addr1 = '0, bp_ctrl = '0;
    logic        rsp_valid, align_abort, bp_hit;
    logic [31:0] rsp_addr;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    // Expected response of the previously driven cycle
    bit          e_valid = 1'b0, e_abort = 1'b0, e_hit = 1'b0;
    logic [31:0] e_addr = '0;
    string       e_addr_tag = "R3", e_hit_tag = "R7", e_abort_tag = "R5";

    always #10 clk = ~clk;

    mac_gate u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_store(req_store),
        .req_addr(req_addr), .pid_reg(pid_reg), .align_en(align_en),
        .bp_addr0(bp_addr0), .bp_addr1(bp_addr1), .bp_ctrl(bp_ctrl),
        .dbg_hold(dbg_hold), .rsp_valid(rsp_valid), .rsp_addr(rsp_addr),
        .align_abort(align_abort), .bp_hit(bp_hit)
    );

    function automatic logic [31:0] m_remap(input logic [31:0] a, input logic [31:0] p);
        if (p[31:25] != 7'd0 && a[31:25] == 7'd0) return a | (p & 32'hFE00_0000);
        return a;
    endfunction

    function automatic bit m_qual(input logic [1:0] q, input bit st);
        case (q)
            2'd1:    return st;
            2'd2:    return 1'b1;
            2'd3:    return !st;
            default: return 1'b0;
        endcase
    endfunction

    function automatic bit m_hit(input logic [31:0] a, input bit st, input logic [31:0] r0,
                                 input logic [31:0] r1, input logic [31:0] c, input bit hold);
        if (hold) return 1'b0;
        if (c[8]) return m_qual(c[1:0], st) && ((a & ~r1) == (r0 & ~r1));
        return (m_qual(c[1:0], st) && a[31:2] == r0[31:2]) ||
               (m_qual(c[3:2], st) && a[31:2] == r1[31:2]);
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Check the previous response, then drive a new request
    task automatic step(input bit v, input bit st, input logic [31:0] a, input logic [31:0] p,
                        input bit al, input logic [31:0] r0, input logic [31:0] r1,
                        input logic [31:0] c, input bit hold, input string atag,
                        input string htag);
        @(negedge clk);
        chk("R2 valid", {31'd0, rsp_valid}, {31'd0, e_valid});
        if (e_valid) begin
            chk(e_addr_tag, rsp_addr, e_addr);
            chk(e_abort_tag, {31'd0, align_abort}, {31'd0, e_abort});
            chk(e_hit_tag, {31'd0, bp_hit}, {31'd0, e_hit});
        end else begin
            chk("R11 abort idle", {31'd0, align_abort}, 32'd0);
            chk("R11 hit idle", {31'd0, bp_hit}, 32'd0);
        end
        req_valid = v; req_store = st; req_addr = a; pid_reg = p; align_en = al;
        bp_addr0 = r0; bp_addr1 = r1; bp_ctrl = c; dbg_hold = hold;
        e_valid     = v;
        e_addr      = m_remap(a, p);
        e_abort     = al && (a[1:0] != 2'b00);
        e_hit       = m_hit(m_remap(a, p), st, r0, r1, c, hold);
        e_addr_tag  = atag;
        e_hit_tag   = htag;
        e_abort_tag = "R5 abort";
    endtask

    initial begin
        #(20 * 200000);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected finish");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        #25;
        // R1 reset state
        chk("R1 valid", {31'd0, rsp_valid}, 32'd0);
        chk("R1 addr", rsp_addr, 32'd0);
        chk("R1 abort", {31'd0, align_abort}, 32'd0);
        chk("R1 hit", {31'd0, bp_hit}, 32'd0);
        @(negedge clk);
        rst_n = 1'b1;

        // R11 idle cycle with matching setup
        step(0, 1, 32'h0000_1000, 0, 1, 32'h0000_1000, 0, 32'h2, 0, "R11", "R11");
        // R3 remap
        step(1, 0, 32'h0000_1000, 32'h0A00_0000, 0, 0, 0, 0, 0, "R3 remap", "R6 off");
        // R4 pass-through: high bits set, then pid zero
        step(1, 0, 32'h4000_1000, 32'h0A00_0000, 0, 0, 0, 0, 0, "R4 high", "R6 off");
        step(1, 0, 32'h0000_1000, 32'h01FF_FFFF, 0, 0, 0, 0, 0, "R4 pid0", "R6 off");
        // R5 alignment
        step(1, 0, 32'h0000_2002, 0, 1, 0, 0, 0, 0, "R2 addr", "R6 off");
        step(1, 0, 32'h0000_2003, 0, 0, 0, 0, 0, 0, "R2 addr", "R6 off");
        step(1, 0, 32'h0000_2004, 0, 1, 0, 0, 0, 0, "R2 addr", "R6 off");
        // R6 qualifiers on comparator 0
        step(1, 0, 32'h0000_3000, 0, 0, 32'h0000_3000, 0, 32'h1, 0, "R2 addr", "R6 store-only load");
        step(1, 1, 32'h0000_3000, 0, 0, 32'h0000_3000, 0, 32'h1, 0, "R2 addr", "R6 store-only store");
        step(1, 0, 32'h0000_3000, 0, 0, 32'h0000_3000, 0, 32'h3, 0, "R2 addr", "R6 load-only load");
        step(1, 1, 32'h0000_3000, 0, 0, 32'h0000_3000, 0, 32'h3, 0, "R2 addr", "R6 load-only store");
        step(1, 1, 32'h0000_3000, 0, 0, 32'h0000_3000, 0, 32'h2, 0, "R2 addr", "R6 any");
        // R7 comparator 1 via bits 3:2, low bits ignored
        step(1, 1, 32'h0000_4003, 0, 0, 0, 32'h0000_4000, 32'h4, 0, "R2 addr", "R7 cmp1");
        step(1, 1, 32'h0000_4004, 0, 0, 0, 32'h0000_4000, 32'h4, 0, "R2 addr", "R7 cmp1 miss");
        step(1, 0, 32'h0000_4000, 0, 0, 32'h0000_4000, 32'h0000_4000, 32'hA, 0, "R2 addr", "R7 both");
        // R8 mask mode
        step(1, 0, 32'h0000_20A0, 0, 0, 32'h0000_2000, 32'h0000_00F0, 32'h102, 0, "R2 addr", "R8 masked hit");
        step(1, 0, 32'h0000_2100, 0, 0, 32'h0000_2000, 32'h0000_00F0, 32'h102, 0, "R2 addr", "R8 masked miss");
        step(1, 0, 32'h0000_2001, 0, 0, 32'h0000_2000, 32'h0000_00F0, 32'h102, 0, "R2 addr", "R8 no word dc");
        step(1, 0, 32'h0000_00F0, 0, 0, 0, 32'h0000_00F0, 32'h108, 0, "R2 addr", "R8 cmp1 off");
        // R9 remapped compare
        step(1, 0, 32'h0000_3000, 32'h0A00_0000, 0, 32'h0A00_3000, 0, 32'h2, 0, "R3 remap", "R9 mapped hit");
        step(1, 0, 32'h0000_3000, 32'h0A00_0000, 0, 32'h0000_3000, 0, 32'h2, 0, "R3 remap", "R9 raw miss");
        // R10 debug hold
        step(1, 0, 32'h0000_3000, 0, 0, 32'h0000_3000, 0, 32'h2, 1, "R2 addr", "R10 hold");

        // Random traffic
        for (int i = 0; i < 3000; i++) begin
            logic [31:0] a, p, r0, r1, c, m;
            a = $urandom;
            if ($urandom_range(1, 0) == 1) a[31:25] = 7'd0;
            p = ($urandom_range(9, 0) < 3) ? 32'd0 : $urandom;
            m = m_remap(a, p);
            r0 = ($urandom_range(1, 0) == 1) ? (m ^ ($urandom & 32'h3)) : $urandom;
            r1 = ($urandom_range(3, 0) == 0) ? (m ^ ($urandom & 32'h3)) : $urandom;
            c  = {23'd0, ($urandom_range(3, 0) == 0), 4'd0, 4'($urandom)};
            if (c[8] && $urandom_range(1, 0) == 1) r1 = (r0 ^ m) | ($urandom & 32'h0000_FFFF);
            step($urandom_range(7, 0) != 0, 1'($urandom), a, p, 1'($urandom), r0, r1, c,
                 $urandom_range(4, 0) == 0, "R3 R4 random", "R7 R8 random");
        end
        step(0, 0, 0, 0, 0, 0, 0, 0, 0, "R2", "R11");
        step(0, 0, 0, 0, 0, 0, 0, 0, 0, "R2", "R11");
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule